// File: doc/BRIEF.md
# Shadow Memory Attribute Router

This block sits on the processor memory request path and decides, for every read or write, whether the access goes to main DRAM or to the ROM on the downstream bus. A fixed window of the address map is split into equal segments. Each segment has a two-bit attribute that picks the target for reads and the target for writes separately. Firmware can therefore copy a ROM image into DRAM, by reading the segment from ROM and writing the same addresses into DRAM, and then switch the segment so that it runs from DRAM while DRAM stays protected from writes.

Requests enter on a valid/ready channel carrying an address and a read/write flag. The routing decision leaves one cycle later on a second valid/ready channel, together with the address and the access kind. An upstream request is taken when `req_valid` and `req_ready` are both high at a clock edge. A routed result is consumed when `rt_valid` and `rt_ready` are both high. While the result is held back, it stays unchanged and no new request is taken. The attribute bank is written through a plain single-cycle write strobe.

Top module: `shadow_router`

## Requirements
- R1: After reset `rt_valid` is 0, `req_ready` is 1, and every segment attribute is 00, so in-window accesses go to ROM.
- R2: With attribute 00, both reads and writes in the segment route to ROM (`rt_dram` = 0).
- R3: With attribute 11, both reads and writes in the segment route to DRAM (`rt_dram` = 1).
- R4: Attribute bit 0 selects DRAM for reads. With attribute 01, reads route to DRAM and writes route to ROM, so DRAM is never modified.
- R5: Attribute bit 1 selects DRAM for writes. With attribute 10 (the copy phase), reads route to ROM and writes route to DRAM.
- R6: Addresses outside the window 0xC0000–0xDFFFF route to DRAM whatever the attributes hold.
- R7: An attribute write takes effect for the first request accepted after the write cycle. A request accepted in the same cycle as the write uses the old attribute.
- R8: `req_ready` is high exactly when the output is empty or being consumed. While `rt_valid` is high and `rt_ready` is low, the output fields do not change.
- R9: An accepted request appears on the output on the next cycle, with the address and read/write flag unchanged and in acceptance order.
- R10: Inside the window, the segment index is address bits [16:14]. Writing the attribute of one segment leaves all the other segments unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | 20 | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| rt_valid | output | 1 | Routed result present |
| rt_ready | input | 1 | Downstream takes the result |
| rt_addr | output | 20 | Address of the routed access |
| rt_write | output | 1 | Access kind of the routed access |
| rt_dram | output | 1 | 1 = DRAM, 0 = ROM bus |
| attr_we | input | 1 | Attribute write strobe |
| attr_idx | input | 3 | Segment whose attribute is written |
| attr_val | input | 2 | New attribute: bit 0 read-to-DRAM, bit 1 write-to-DRAM |

## Verification
The properties assume that the upstream side follows the valid/ready rules. They also assume that `req_addr` and `req_write` are meaningful whenever `req_valid` is high, and that `rt_ready` is a proper downstream acceptance signal. The bench drives all inputs only on falling edges. It holds a request steady until it sees `req_ready` high, and it only writes attribute indices that address a real segment. Back-pressure comes from a pseudo-random `rt_ready` pattern, so stalls of several cycles and back-to-back transfers both occur.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  typedef enum logic {
    TGT_ROM  = 1'b0,
    TGT_DRAM = 1'b1
  } target_e;

  // one segment attribute; bit order is the write-port encoding
  typedef struct packed {
    logic wr_dram;
    logic rd_dram;
  } seg_attr_t;

  localparam int ATTR_W = $bits(seg_attr_t);
endpackage

// File: rtl/shadow_attr_bank.sv
module shadow_attr_bank
  import shadow_pkg::*;
#(
  parameter int SEG_COUNT = 8,
  localparam int IDX_W = (SEG_COUNT > 1) ? $clog2(SEG_COUNT) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  seg_attr_t                   wr_val,
  output logic [SEG_COUNT*ATTR_W-1:0] attr_flat
);
  for (genvar g = 0; g < SEG_COUNT; g++) begin : g_seg
    seg_attr_t attr_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        attr_q <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        attr_q <= wr_val;
      end
    end
    assign attr_flat[g*ATTR_W +: ATTR_W] = attr_q;
  end
endmodule

// File: rtl/shadow_decode.sv
module shadow_decode
  import shadow_pkg::*;
#(
  parameter int          ADDR_W    = 20,
  parameter int          SEG_COUNT = 8,
  parameter int          SEG_LOG2  = 14,
  parameter logic [ADDR_W-1:0] WIN_BASE = 20'hC0000,
  localparam int IDX_W = (SEG_COUNT > 1) ? $clog2(SEG_COUNT) : 1
) (
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        is_write,
  input  logic [SEG_COUNT*ATTR_W-1:0] attr_flat,
  output target_e                     target
);
  localparam logic [ADDR_W:0] WIN_LO = {1'b0, WIN_BASE};
  localparam logic [ADDR_W:0] WIN_HI = WIN_LO + ((ADDR_W+1)'(SEG_COUNT) << SEG_LOG2);

  logic [ADDR_W:0]   addr_ext;
  logic [ADDR_W:0]   offset;
  logic              in_window;
  logic [IDX_W-1:0]  seg_idx;
  seg_attr_t         seg_attr;

  always_comb begin
    addr_ext  = {1'b0, addr};
    offset    = addr_ext - WIN_LO;
    in_window = (addr_ext >= WIN_LO) && (addr_ext < WIN_HI);
    seg_idx   = offset[SEG_LOG2 +: IDX_W];
    seg_attr  = attr_flat[seg_idx*ATTR_W +: ATTR_W];
    if (!in_window) begin
      target = TGT_DRAM;
    end else if (is_write) begin
      target = seg_attr.wr_dram ? TGT_DRAM : TGT_ROM;
    end else begin
      target = seg_attr.rd_dram ? TGT_DRAM : TGT_ROM;
    end
  end
endmodule

// File: rtl/shadow_route_stage.sv
module shadow_route_stage
  import shadow_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_write,
  input  target_e           in_target,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_write,
  output target_e           out_target
);
  logic load;

  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_addr   <= '0;
      out_write  <= 1'b0;
      out_target <= TGT_ROM;
    end else begin
      if (load) begin
        out_valid  <= 1'b1;
        out_addr   <= in_addr;
        out_write  <= in_write;
        out_target <= in_target;
      end else if (out_ready) begin
        out_valid  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/shadow_router.sv
module shadow_router
  import shadow_pkg::*;
#(
  parameter int          ADDR_W    = 20,
  parameter int          SEG_COUNT = 8,
  parameter int          SEG_LOG2  = 14,
  parameter logic [ADDR_W-1:0] WIN_BASE = 20'hC0000,
  localparam int IDX_W = (SEG_COUNT > 1) ? $clog2(SEG_COUNT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              rt_valid,
  input  logic              rt_ready,
  output logic [ADDR_W-1:0] rt_addr,
  output logic              rt_write,
  output logic              rt_dram,
  input  logic              attr_we,
  input  logic [IDX_W-1:0]  attr_idx,
  input  logic [ATTR_W-1:0] attr_val
);
  logic [SEG_COUNT*ATTR_W-1:0] attr_flat;
  target_e                     req_target;
  target_e                     rt_target;

  shadow_attr_bank #(.SEG_COUNT(SEG_COUNT)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (attr_we),
    .wr_idx    (attr_idx),
    .wr_val    (seg_attr_t'(attr_val)),
    .attr_flat (attr_flat)
  );

  shadow_decode #(
    .ADDR_W    (ADDR_W),
    .SEG_COUNT (SEG_COUNT),
    .SEG_LOG2  (SEG_LOG2),
    .WIN_BASE  (WIN_BASE)
  ) u_decode (
    .addr      (req_addr),
    .is_write  (req_write),
    .attr_flat (attr_flat),
    .target    (req_target)
  );

  shadow_route_stage #(.ADDR_W(ADDR_W)) u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (req_valid),
    .in_ready   (req_ready),
    .in_addr    (req_addr),
    .in_write   (req_write),
    .in_target  (req_target),
    .out_valid  (rt_valid),
    .out_ready  (rt_ready),
    .out_addr   (rt_addr),
    .out_write  (rt_write),
    .out_target (rt_target)
  );

  assign rt_dram = (rt_target == TGT_DRAM);
endmodule

// File: rtl/shadow_router_chk.sv
module shadow_router_chk #(
  parameter int          ADDR_W    = 20,
  parameter int          SEG_COUNT = 8,
  parameter int          SEG_LOG2  = 14,
  parameter logic [ADDR_W-1:0] WIN_BASE = 20'hC0000
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic [ADDR_W-1:0]       req_addr,
  input logic                    req_write,
  input logic                    rt_valid,
  input logic                    rt_ready,
  input logic [ADDR_W-1:0]       rt_addr,
  input logic                    rt_write,
  input logic                    rt_dram,
  input logic [SEG_COUNT*2-1:0]  attr_flat
);
  localparam logic [ADDR_W:0] LO = {1'b0, WIN_BASE};
  localparam logic [ADDR_W:0] HI = LO + ((ADDR_W+1)'(SEG_COUNT) << SEG_LOG2);

  function automatic logic inside_win(input logic [ADDR_W-1:0] a);
    return ({1'b0, a} >= LO) && ({1'b0, a} < HI);
  endfunction

  function automatic logic want_dram(input logic [ADDR_W-1:0] a, input logic w,
                                     input logic [SEG_COUNT*2-1:0] at);
    logic [ADDR_W:0] off;
    int              s;
    off = {1'b0, a} - LO;
    s   = int'(off >> SEG_LOG2);
    if (!inside_win(a)) return 1'b1;
    return w ? at[s*2+1] : at[s*2];
  endfunction

  logic exp_dram_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      exp_dram_q <= 1'b1;
    else if (req_valid && req_ready) exp_dram_q <= want_dram(req_addr, req_write, attr_flat);
  end

  // R8: a stalled result does not move
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rt_valid && !rt_ready |=> rt_valid && $stable(rt_addr) && $stable(rt_write) && $stable(rt_dram));

  // R8: no acceptance while a result is stalled
  p_no_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rt_valid && !rt_ready |-> !req_ready);

  // R9: accepted request shows up next cycle unchanged
  p_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rt_valid && rt_addr == $past(req_addr) && rt_write == $past(req_write));

  // R6: outside the window always DRAM
  p_outside_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rt_valid && !inside_win(rt_addr) |-> rt_dram);

  // R7: routing uses the attributes present at acceptance
  p_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rt_dram == exp_dram_q);
endmodule

bind shadow_router shadow_router_chk #(
  .ADDR_W    (ADDR_W),
  .SEG_COUNT (SEG_COUNT),
  .SEG_LOG2  (SEG_LOG2),
  .WIN_BASE  (WIN_BASE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .req_write (req_write),
  .rt_valid  (rt_valid),
  .rt_ready  (rt_ready),
  .rt_addr   (rt_addr),
  .rt_write  (rt_write),
  .rt_dram   (rt_dram),
  .attr_flat (attr_flat)
);

// File: tb/test_shadow_router.sv
`timescale 1ns/1ps
module test_shadow_router;
  localparam int AW = 20;
  localparam logic [AW-1:0] BASE = 20'hC0000;
  localparam int NSEG = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rt_ready = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic attr_we = 1'b0;
  logic [2:0] attr_idx = '0;
  logic [1:0] attr_val = '0;
  logic req_ready, rt_valid, rt_write, rt_dram;
  logic [AW-1:0] rt_addr;

  int checks = 0, failures = 0, cycles = 0;
  logic [1:0] model [NSEG];
  logic [AW+1:0] exp_q [$];
  string tag_q [$];
  logic bp_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  bit done = 0;

  always #10 clk = ~clk;

  shadow_router i_shadow_router (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .rt_valid(rt_valid),
    .rt_ready(rt_ready), .rt_addr(rt_addr), .rt_write(rt_write), .rt_dram(rt_dram),
    .attr_we(attr_we), .attr_idx(attr_idx), .attr_val(attr_val));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic route(input logic [AW-1:0] a, input logic w);
    int s;
    if (a < BASE || a >= BASE + 20'h20000) return 1'b1;
    s = int'((a - BASE) >> 14);
    return w ? model[s][1] : model[s][0];
  endfunction

  // driver: called at a falling edge, returns at a falling edge
  task automatic send(input logic [AW-1:0] a, input logic w, input string tag);
    req_valid = 1'b1; req_addr = a; req_write = w;
    forever begin
      #5;
      if (req_ready) begin
        exp_q.push_back({a, w, route(a, w)});
        tag_q.push_back(tag);
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  task automatic set_attr(input int s, input logic [1:0] v);
    attr_we = 1'b1; attr_idx = 3'(s); attr_val = v;
    @(negedge clk);
    model[s] = v;
    attr_we = 1'b0;
  endtask

  // back-pressure source
  initial forever begin
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rt_ready = bp_en ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  // monitor / scoreboard
  initial begin
    logic stall_p = 1'b0;
    logic [AW+1:0] prev = '0;
    forever begin
      @(negedge clk); #5;
      if (rst_n) begin
        if (stall_p)
          check(rt_valid && {rt_addr, rt_write, rt_dram} == prev, "R8", "stalled output moved",
                32'({rt_valid, rt_addr, rt_write, rt_dram}), 32'({1'b1, prev}));
        if (rt_valid && rt_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R9", "unexpected output", 32'(rt_addr), 32'hx);
          end else begin
            logic [AW+1:0] e;
            string t;
            e = exp_q.pop_front(); t = tag_q.pop_front();
            check(rt_addr == e[AW+1:2] && rt_write == e[1], "R9", "address/kind",
                  32'({rt_addr, rt_write}), 32'(e[AW+1:1]));
            check(rt_dram == e[0], t, "route", 32'(rt_dram), 32'(e[0]));
          end
        end
        stall_p = rt_valid && !rt_ready;
        prev = {rt_addr, rt_write, rt_dram};
      end
    end
  end

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++; checks++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < NSEG; i++) model[i] = 2'b00;
    repeat (3) @(negedge clk);
    #5;
    check(rt_valid == 1'b0, "R1", "rt_valid after reset", 32'(rt_valid), 0);
    check(req_ready == 1'b1, "R1", "req_ready after reset", 32'(req_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R2: reset attributes send window accesses to ROM
    send(20'hC0000, 1'b0, "R1");
    send(20'hDFFFF, 1'b1, "R2");
    send(20'hC4010, 1'b1, "R2");
    // R9: one-cycle latency
    send(20'hC8004, 1'b0, "R2");
    #5;
    check(rt_valid && rt_addr == 20'hC8004, "R9", "latency", 32'(rt_addr), 32'hC8004);
    @(negedge clk);

    // R6: outside window
    send(20'h00000, 1'b0, "R6");
    send(20'hBFFFF, 1'b1, "R6");
    send(20'hE0000, 1'b0, "R6");
    send(20'hFFFFF, 1'b1, "R6");

    // R5: copy phase
    set_attr(2, 2'b10);
    send(20'hC8100, 1'b0, "R5");
    send(20'hC8100, 1'b1, "R5");
    // R4: read-only in DRAM
    set_attr(2, 2'b01);
    send(20'hCBFFF, 1'b0, "R4");
    send(20'hCBFFF, 1'b1, "R4");
    // R3 and R10
    set_attr(5, 2'b11);
    send(20'hD4000, 1'b0, "R3");
    send(20'hD7FFE, 1'b1, "R3");
    send(20'hD3FFF, 1'b1, "R10");
    send(20'hD8000, 1'b0, "R10");
    send(20'hC8000, 1'b0, "R10");
    // R6 regardless of attributes
    for (int i = 0; i < NSEG; i++) set_attr(i, 2'b00);
    send(20'hE0004, 1'b1, "R6");

    // R7: same-cycle update uses old attribute, next request uses new
    fork
      set_attr(1, 2'b11);
      send(20'hC4000, 1'b0, "R7");
    join
    send(20'hC4000, 1'b0, "R7");

    // back-pressure burst (R8, R9 via scoreboard)
    set_attr(0, 2'b10); set_attr(3, 2'b01); set_attr(6, 2'b11);
    bp_en = 1'b1;
    for (int i = 0; i < 60; i++) begin
      logic [AW-1:0] a;
      a = (i % 5 == 0) ? 20'(i * 20'h1111) : 20'(BASE + 20'(i * 20'h0B13));
      send(a, 1'(i & 1), "R8");
    end
    bp_en = 1'b0;
    for (int i = 0; i < 50 && exp_q.size() != 0; i++) @(negedge clk);
    check(exp_q.size() == 0, "R9", "results left undelivered", 32'(exp_q.size()), 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule